// File: doc/BRIEF.md
# Light-Load Frequency Foldback Controller

This block is the digital operating-point selector of a peak-current-mode converter controller. It takes a sampled feedback level, given as an unsigned millivolt code, and produces three outputs: the switching period as a count of system clock cycles, the peak-current set point as a millivolt code, and a skip-cycle enable. A strobe marks the start of each switching cycle, and the outputs change only on that strobe, so a period already in progress is never altered.

The feedback range is split into four regions. At high feedback the converter runs at its nominal frequency, either 65 kHz or 100 kHz. Lower down the frequency falls linearly to a fixed 26 kHz minimum. Lower still the peak set point freezes. At the bottom, skip mode stops switching, and switching resumes only after a hysteresis band is crossed. The peak set point follows the feedback level divided by four and has its own breakpoints, separate from the frequency breakpoints.

A slow triangular dither spreads the switching energy. It is applied in every region, foldback included, and it steps once per switching cycle.

Top module: `lload_fold_ctl`

## Requirements
- R1: With `fb_mv` >= 1900 at a strobe, the base period is CLK_HZ/65000 (integer division) when `fast_sel`=0, or CLK_HZ/100000 when `fast_sel`=1.
- R2: With 1500 < `fb_mv` < 1900, the base frequency is f = 26000 + ((fnom-26000)*(fb_mv-1500))/400 Hz, and the base period is CLK_HZ/f. Both divisions are integer divisions.
- R3: With `fb_mv` <= 1500, the base period is CLK_HZ/26000.
- R4: The set point `ipk_mv` equals floor(`fb_mv`/4) for 1000 <= `fb_mv` < 3200, and 800 for `fb_mv` >= 3200.
- R5: With `fb_mv` < 1000, `ipk_mv` is frozen at 250.
- R6: Skip mode sets `skip_en`=1 when `fb_mv` <= 800 at a strobe. Once set, it stays set until a strobe with `fb_mv` > 850.
- R7: Dither uses a phase p that moves by one per strobe between -JIT_STEPS and +JIT_STEPS and reverses direction at each end. It starts at 0 and rises first. The output period is base + trunc(base*p*5/(100*JIT_STEPS)), and each strobe uses the phase held before that strobe.
- R8: Outputs change only on a clock edge where `cyc_start`=1. Between strobes they hold their values whatever `fb_mv` and `fast_sel` do.
- R9: In reset, the outputs are `period_cyc`=CLK_HZ/65000, `ipk_mv`=250 and `skip_en`=1, and the dither phase is 0 and rising.
- R10: The dither of R7 keeps running in the linear foldback region and in the minimum-frequency region, where it swings the period by ±5% of CLK_HZ/26000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-cycle strobe at the start of each switching cycle |
| fast_sel | input | 1 | Nominal frequency select: 0 = 65 kHz, 1 = 100 kHz |
| fb_mv | input | FB_W (12) | Sampled feedback level in millivolts |
| period_cyc | output | PER_W | Switching period in system clock cycles |
| ipk_mv | output | IPK_W (10) | Peak-current set point in millivolts |
| skip_en | output | 1 | Skip-cycle enable; 1 = suppress switching |

## Verification
The bench keeps the default 200 MHz clock value, which gives periods of 3076, 2000 and 7692 cycles. It lowers JIT_STEPS to 8, so both turnaround points of the dither triangle are reached within a few dozen strobes. The swing extremes can then be measured at fixed feedback in the nominal region and in the minimum-frequency region. Feedback sweeps in both frequency selections cross every breakpoint. Directed steps probe the exact edges of the set point and of the skip hysteresis.

// File: rtl/lload_fold_pkg.sv
`timescale 1ns/1ps
package lload_fold_pkg;

    // Direction of the triangular dither phase
    typedef enum logic {
        JIT_UP   = 1'b0,
        JIT_DOWN = 1'b1
    } jit_dir_e;

    // Operating region of the frequency map
    typedef enum logic [1:0] {
        RGN_NOM  = 2'd0,
        RGN_FOLD = 2'd1,
        RGN_MIN  = 2'd2
    } freq_rgn_e;

endpackage

// File: rtl/lload_freq_map.sv
`timescale 1ns/1ps
module lload_freq_map
    import lload_fold_pkg::*;
#(
    parameter int CLK_HZ     = 200_000_000,
    parameter int F_LOW_HZ   = 65_000,
    parameter int F_HIGH_HZ  = 100_000,
    parameter int F_MIN_HZ   = 26_000,
    parameter int FB_W       = 12,
    parameter int FOLD_HI_MV = 1900,
    parameter int FOLD_LO_MV = 1500,
    parameter int PER_W      = 13
) (
    input  logic [FB_W-1:0]  fb_mv,
    input  logic             fast_sel,
    output logic [PER_W-1:0] base_per,
    output freq_rgn_e        rgn
);
    localparam int SPAN_MV = FOLD_HI_MV - FOLD_LO_MV;

    int fb_i;
    int f_nom;
    int f_hz;

    always_comb begin
        fb_i  = int'(fb_mv);
        f_nom = fast_sel ? F_HIGH_HZ : F_LOW_HZ;
        if (fb_i >= FOLD_HI_MV) begin
            rgn  = RGN_NOM;
            f_hz = f_nom;
        end else if (fb_i <= FOLD_LO_MV) begin
            rgn  = RGN_MIN;
            f_hz = F_MIN_HZ;
        end else begin
            rgn  = RGN_FOLD;
            f_hz = F_MIN_HZ + ((f_nom - F_MIN_HZ) * (fb_i - FOLD_LO_MV)) / SPAN_MV;
        end
        base_per = PER_W'(CLK_HZ / f_hz);
    end
endmodule

// File: rtl/lload_ipk_map.sv
`timescale 1ns/1ps
module lload_ipk_map #(
    parameter int FB_W       = 12,
    parameter int IPK_W      = 10,
    parameter int KDIV_SHIFT = 2,
    parameter int CLAMP_MV   = 3200,
    parameter int FREEZE_MV  = 1000,
    parameter int IPK_MAX_MV = 800,
    parameter int IPK_FRZ_MV = 250
) (
    input  logic [FB_W-1:0]  fb_mv,
    output logic [IPK_W-1:0] ipk
);
    logic [FB_W-1:0] scaled;

    always_comb begin
        scaled = fb_mv >> KDIV_SHIFT;
        if (int'(fb_mv) >= CLAMP_MV)
            ipk = IPK_W'(IPK_MAX_MV);
        else if (int'(fb_mv) < FREEZE_MV)
            ipk = IPK_W'(IPK_FRZ_MV);
        else
            ipk = IPK_W'(scaled);
    end
endmodule

// File: rtl/lload_jitter.sv
`timescale 1ns/1ps
module lload_jitter #(
    parameter int PER_W     = 13,
    parameter int PH_W      = 5,
    parameter int JIT_STEPS = 68,
    parameter int JIT_PCT   = 5
) (
    input  logic [PER_W-1:0]        base_per,
    input  logic signed [PH_W-1:0]  phase,
    output logic [PER_W-1:0]        per_out
);
    generate
        if (JIT_PCT == 0) begin : g_bypass
            assign per_out = base_per;
        end else begin : g_dither
            int b;
            int p;
            int ofs;
            always_comb begin
                b       = int'(base_per);
                p       = int'(phase);
                ofs     = (b * p * JIT_PCT) / (100 * JIT_STEPS);
                per_out = PER_W'(b + ofs);
            end
        end
    endgenerate
endmodule

// File: rtl/lload_fold_ctl.sv
`timescale 1ns/1ps
module lload_fold_ctl
    import lload_fold_pkg::*;
#(
    parameter int CLK_HZ     = 200_000_000,
    parameter int F_LOW_HZ   = 65_000,
    parameter int F_HIGH_HZ  = 100_000,
    parameter int F_MIN_HZ   = 26_000,
    parameter int FB_W       = 12,
    parameter int FOLD_HI_MV = 1900,
    parameter int FOLD_LO_MV = 1500,
    parameter int CLAMP_MV   = 3200,
    parameter int FREEZE_MV  = 1000,
    parameter int SKIP_MV    = 800,
    parameter int SKIP_HYST  = 50,
    parameter int KDIV_SHIFT = 2,
    parameter int IPK_MAX_MV = 800,
    parameter int IPK_FRZ_MV = 250,
    parameter int JIT_STEPS  = 68,
    parameter int JIT_PCT    = 5,
    parameter int PER_W      = $clog2(CLK_HZ / F_MIN_HZ + (CLK_HZ / F_MIN_HZ) * JIT_PCT / 100 + 2),
    parameter int IPK_W      = $clog2(IPK_MAX_MV + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic             fast_sel,
    input  logic [FB_W-1:0]  fb_mv,
    output logic [PER_W-1:0] period_cyc,
    output logic [IPK_W-1:0] ipk_mv,
    output logic             skip_en
);
    localparam int PH_W = $clog2(JIT_STEPS + 1) + 1;
    localparam logic signed [PH_W-1:0] PH_MAX = PH_W'(JIT_STEPS);
    localparam logic signed [PH_W-1:0] PH_MIN = -PH_MAX;
    localparam logic [FB_W-1:0] SKIP_ON_MV  = FB_W'(SKIP_MV);
    localparam logic [FB_W-1:0] SKIP_OFF_MV = FB_W'(SKIP_MV + SKIP_HYST);

    typedef struct packed {
        logic [PER_W-1:0]       per;
        logic [IPK_W-1:0]       ipk;
        logic                   skip;
        logic signed [PH_W-1:0] ph;
        jit_dir_e               dir;
    } st_t;

    st_t st_d, st_q;

    logic [PER_W-1:0] base_per;
    logic [PER_W-1:0] jit_per;
    logic [IPK_W-1:0] ipk_map;
    freq_rgn_e        rgn;

    lload_freq_map #(
        .CLK_HZ(CLK_HZ), .F_LOW_HZ(F_LOW_HZ), .F_HIGH_HZ(F_HIGH_HZ),
        .F_MIN_HZ(F_MIN_HZ), .FB_W(FB_W), .FOLD_HI_MV(FOLD_HI_MV),
        .FOLD_LO_MV(FOLD_LO_MV), .PER_W(PER_W)
    ) u_freq (
        .fb_mv(fb_mv), .fast_sel(fast_sel), .base_per(base_per), .rgn(rgn)
    );

    lload_ipk_map #(
        .FB_W(FB_W), .IPK_W(IPK_W), .KDIV_SHIFT(KDIV_SHIFT),
        .CLAMP_MV(CLAMP_MV), .FREEZE_MV(FREEZE_MV),
        .IPK_MAX_MV(IPK_MAX_MV), .IPK_FRZ_MV(IPK_FRZ_MV)
    ) u_ipk (
        .fb_mv(fb_mv), .ipk(ipk_map)
    );

    lload_jitter #(
        .PER_W(PER_W), .PH_W(PH_W), .JIT_STEPS(JIT_STEPS), .JIT_PCT(JIT_PCT)
    ) u_jit (
        .base_per(base_per), .phase(st_q.ph), .per_out(jit_per)
    );

    // Region is exposed for visibility of the map decision; the period
    // itself already carries it.
    logic rgn_unused;
    assign rgn_unused = ^rgn;

    always_comb begin
        st_d = st_q;
        if (cyc_start) begin
            st_d.per = jit_per;
            st_d.ipk = ipk_map;
            if (st_q.skip)
                st_d.skip = !(fb_mv > SKIP_OFF_MV);
            else
                st_d.skip = (fb_mv <= SKIP_ON_MV);
            if (st_q.dir == JIT_UP) begin
                st_d.ph = st_q.ph + PH_W'(1);
                if (st_d.ph == PH_MAX) st_d.dir = JIT_DOWN;
            end else begin
                st_d.ph = st_q.ph - PH_W'(1);
                if (st_d.ph == PH_MIN) st_d.dir = JIT_UP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.per  <= PER_W'(CLK_HZ / F_LOW_HZ);
            st_q.ipk  <= IPK_W'(IPK_FRZ_MV);
            st_q.skip <= 1'b1;
            st_q.ph   <= '0;
            st_q.dir  <= JIT_UP;
        end else begin
            st_q <= st_d;
        end
    end

    assign period_cyc = st_q.per;
    assign ipk_mv     = st_q.ipk;
    assign skip_en    = st_q.skip;
endmodule

// File: rtl/lload_fold_chk.sv
`timescale 1ns/1ps
module lload_fold_chk #(
    parameter int CLK_HZ     = 200_000_000,
    parameter int F_LOW_HZ   = 65_000,
    parameter int F_HIGH_HZ  = 100_000,
    parameter int F_MIN_HZ   = 26_000,
    parameter int FB_W       = 12,
    parameter int FREEZE_MV  = 1000,
    parameter int SKIP_MV    = 800,
    parameter int SKIP_HYST  = 50,
    parameter int IPK_MAX_MV = 800,
    parameter int IPK_FRZ_MV = 250,
    parameter int JIT_PCT    = 5,
    parameter int PER_W      = 13,
    parameter int IPK_W      = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_start,
    input logic [FB_W-1:0]  fb_mv,
    input logic [PER_W-1:0] period_cyc,
    input logic [IPK_W-1:0] ipk_mv,
    input logic             skip_en
);
    localparam int P_FAST = CLK_HZ / F_HIGH_HZ;
    localparam int P_SLOW = CLK_HZ / F_MIN_HZ;
    localparam int P_LO   = P_FAST - (P_FAST * JIT_PCT) / 100 - 1;
    localparam int P_HI   = P_SLOW + (P_SLOW * JIT_PCT) / 100 + 1;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_start |=> ($stable(period_cyc) && $stable(ipk_mv) && $stable(skip_en))); // R8

    AST_SKIP_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && int'(fb_mv) <= SKIP_MV) |=> skip_en); // R6

    AST_SKIP_HYST: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && skip_en && int'(fb_mv) <= SKIP_MV + SKIP_HYST) |=> skip_en); // R6

    AST_SKIP_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && int'(fb_mv) > SKIP_MV + SKIP_HYST) |=> !skip_en); // R6

    AST_IPK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && int'(fb_mv) < FREEZE_MV) |=> (int'(ipk_mv) == IPK_FRZ_MV)); // R5

    AST_IPK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ipk_mv) >= IPK_FRZ_MV && int'(ipk_mv) <= IPK_MAX_MV)); // R4

    AST_PERIOD_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(period_cyc) >= P_LO && int'(period_cyc) <= P_HI)); // R7
endmodule

bind lload_fold_ctl lload_fold_chk #(
    .CLK_HZ(CLK_HZ), .F_LOW_HZ(F_LOW_HZ), .F_HIGH_HZ(F_HIGH_HZ),
    .F_MIN_HZ(F_MIN_HZ), .FB_W(FB_W), .FREEZE_MV(FREEZE_MV),
    .SKIP_MV(SKIP_MV), .SKIP_HYST(SKIP_HYST), .IPK_MAX_MV(IPK_MAX_MV),
    .IPK_FRZ_MV(IPK_FRZ_MV), .JIT_PCT(JIT_PCT), .PER_W(PER_W), .IPK_W(IPK_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .fb_mv(fb_mv),
    .period_cyc(period_cyc), .ipk_mv(ipk_mv), .skip_en(skip_en)
);

// File: tb/lload_fold_ctl_test.sv
`timescale 1ns/1ps
module lload_fold_ctl_test;
    localparam int CLK_HZ = 200_000_000;
    localparam int JS     = 8;
    localparam int PER_W  = $clog2(CLK_HZ / 26000 + (CLK_HZ / 26000) * 5 / 100 + 2);
    localparam int IPK_W  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_start = 1'b0;
    logic fast_sel = 1'b0;
    logic [11:0] fb_mv = 12'd2500;
    logic [PER_W-1:0] period_cyc;
    logic [IPK_W-1:0] ipk_mv;
    logic skip_en;

    always #2.5 clk = ~clk;

    lload_fold_ctl #(.CLK_HZ(CLK_HZ), .JIT_STEPS(JS)) uut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .fast_sel(fast_sel),
        .fb_mv(fb_mv), .period_cyc(period_cyc), .ipk_mv(ipk_mv), .skip_en(skip_en)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_per, m_ipk, m_skip, m_ph, m_up;
    string m_ptag, m_itag;

    function automatic int ref_base(int fb, bit fast);
        int fn, f;
        fn = fast ? 100000 : 65000;
        if (fb >= 1900) f = fn;
        else if (fb <= 1500) f = 26000;
        else f = 26000 + ((fn - 26000) * (fb - 1500)) / 400;
        return CLK_HZ / f;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_per = CLK_HZ / 65000; m_ipk = 250; m_skip = 1;
            m_ph = 0; m_up = 1; m_ptag = "R9"; m_itag = "R9";
        end else if (cyc_start) begin
            int fb, b;
            fb = int'(fb_mv);
            b = ref_base(fb, fast_sel);
            m_per = b + (b * m_ph * 5) / (100 * JS);
            m_ptag = (fb >= 1900) ? "R1 R7" : (fb <= 1500) ? "R3 R10" : "R2 R10";
            if (fb >= 3200) m_ipk = 800;
            else if (fb < 1000) m_ipk = 250;
            else m_ipk = fb / 4;
            m_itag = (fb < 1000) ? "R5" : "R4";
            if (m_skip != 0) m_skip = (fb > 850) ? 0 : 1;
            else m_skip = (fb <= 800) ? 1 : 0;
            if (m_up != 0) begin m_ph++; if (m_ph == JS) m_up = 0; end
            else begin m_ph--; if (m_ph == -JS) m_up = 1; end
        end
    end

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({m_ptag, " period"}, int'(period_cyc), m_per);
            chk({m_itag, " setpoint"}, int'(ipk_mv), m_ipk);
            chk("R6 skip", int'(skip_en), m_skip);
        end
    end

    task automatic strobe(int fb, bit fast);
        @(negedge clk);
        fb_mv = 12'(fb); fast_sel = fast; cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int pmax, pmin, hold_p, hold_i, hold_s;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 reset period", int'(period_cyc), 3076);
        chk("R9 reset setpoint", int'(ipk_mv), 250);
        chk("R9 reset skip", int'(skip_en), 1);
        @(negedge clk); rst_n = 1'b1;

        // R7 dither extremes at nominal 65 kHz (base 3076)
        pmax = 0; pmin = 1 << 20;
        for (int i = 0; i < 40; i++) begin
            strobe(2500, 1'b0);
            if (int'(period_cyc) > pmax) pmax = int'(period_cyc);
            if (int'(period_cyc) < pmin) pmin = int'(period_cyc);
        end
        chk("R7 dither max", pmax, 3229);
        chk("R7 dither min", pmin, 2923);
        chk("R1 setpoint at 2500", int'(ipk_mv), 625);

        // R8 hold between strobes
        hold_p = int'(period_cyc); hold_i = int'(ipk_mv); hold_s = int'(skip_en);
        fb_mv = 12'd100; fast_sel = 1'b1;
        repeat (5) @(negedge clk);
        chk("R8 hold period", int'(period_cyc), hold_p);
        chk("R8 hold setpoint", int'(ipk_mv), hold_i);
        chk("R8 hold skip", int'(skip_en), hold_s);

        // R10 dither in minimum-frequency region (base 7692)
        pmax = 0; pmin = 1 << 20;
        for (int i = 0; i < 40; i++) begin
            strobe(1200, 1'b0);
            if (int'(period_cyc) > pmax) pmax = int'(period_cyc);
            if (int'(period_cyc) < pmin) pmin = int'(period_cyc);
        end
        chk("R10 dither max", pmax, 8076);
        chk("R10 dither min", pmin, 7308);

        // R1 R2 R3 sweeps in both selections
        for (int s = 0; s < 2; s++)
            for (int fb = 3600; fb >= 0; fb -= 25) strobe(fb, s[0]);

        // R4 R5 set point edges
        strobe(3200, 1'b0); chk("R4 clamp 3200", int'(ipk_mv), 800);
        strobe(3199, 1'b0); chk("R4 3199", int'(ipk_mv), 799);
        strobe(1004, 1'b0); chk("R4 1004", int'(ipk_mv), 251);
        strobe(1000, 1'b0); chk("R4 1000", int'(ipk_mv), 250);
        strobe(999, 1'b0);  chk("R5 freeze 999", int'(ipk_mv), 250);
        strobe(4095, 1'b1); chk("R4 clamp 4095", int'(ipk_mv), 800);

        // R6 skip hysteresis
        strobe(900, 1'b0); chk("R6 above band", int'(skip_en), 0);
        strobe(801, 1'b0); chk("R6 801 no entry", int'(skip_en), 0);
        strobe(800, 1'b0); chk("R6 entry 800", int'(skip_en), 1);
        strobe(850, 1'b0); chk("R6 hold 850", int'(skip_en), 1);
        strobe(851, 1'b0); chk("R6 exit 851", int'(skip_en), 0);
        strobe(850, 1'b0); chk("R6 850 stays off", int'(skip_en), 0);

        // R2 fold edges
        for (int fb = 1495; fb <= 1905; fb++) strobe(fb, fb[0]);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule